// File: doc/BRIEF.md
# Direct-Mapped Write-Back Word Cache

This block is a direct-mapped cache placed between a processor port and a slower main-memory port. Addresses count 16-bit words, not bytes. A 16-bit address reaches 65536 words of main memory. The cache holds 2048 words, arranged as 128 lines of 16 words each. Each line keeps a tag, a valid flag and a dirty flag. A read hit or a write hit completes in one cycle. A miss is handled by a small state machine that talks to memory one word at a time, using a request/acknowledge handshake that tolerates any latency.

Read misses allocate a line. If the line being replaced is dirty, all 16 of its words are written back first. The new block is then fetched in ascending word order. The word the processor asked for is returned as soon as it arrives from memory, and the rest of the line keeps filling in the background. Write hits stay in the cache and mark the line dirty. Write misses go straight to memory and do not allocate a line. The processor may present a new request only while `cpu_idle` is high. A request presented at any other time is ignored.

Top module: `dmc_wb_cache`

## Requirements
- R1: The address is split into a tag (bits 15:11), a line index (bits 10:4) and a word offset (bits 3:0). An access is a hit when the indexed line is valid and its stored tag equals the tag bits. On a hit, `cpu_done` pulses in the cycle after acceptance, and for a read `cpu_rdata` carries the addressed word.
- R2: Reset clears every valid flag, so the first access to any line after reset misses.
- R3: A read miss fetches the 16 words of the containing block from memory at addresses {tag, index, 0} up to {tag, index, 15}, in that order. The line then holds the new tag, marked valid and clean.
- R4: On a read miss, `cpu_done` pulses with the addressed word in the cycle after that word's acknowledge. It does not wait for the end of the refill, and `cpu_idle` stays low until the refill ends.
- R5: A write hit updates only the cached word and marks the line dirty. It causes no memory traffic.
- R6: A write miss performs exactly one memory write of the word at its address, with no allocation. `cpu_done` pulses in the cycle after that write's acknowledge.
- R7: When a read miss replaces a valid dirty line, the 16 old words are written to memory at {old tag, index, 0..15}, in ascending order, before the first refill read.
- R8: A victim line that is invalid or clean is never written back.
- R9: Each accepted request produces exactly one `cpu_done` pulse. `cpu_req` has no effect while `cpu_idle` is low.
- R10: While `mem_req` is high and not yet acknowledged, `mem_addr`, `mem_we` and `mem_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Request strobe, sampled while `cpu_idle` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_idle | output | 1 | Controller can accept a request this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid when `cpu_done` is high for a read |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data is valid with it |
| mem_rdata | input | 16 | Memory read data |

## Verification
The embedded properties check the following on every cycle:
- Memory requests hold steady until they are acknowledged.
- A line is never dirty unless it is valid.
- A refill leaves the line valid and clean.
- A write hit leaves the line dirty.
- A write-back hands over directly to a refill.
- No second completion pulse follows an early forwarded word.

Only the scenarios can show the other behaviours:
- The returned data values.
- The hit versus miss latency.
- The exact count and ascending order of write-back and refill addresses.
- That written-back data later reads correctly.
- That a request made while busy leaves both the cache and memory untouched.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int OFF_W  = 4;
    localparam int IDX_W  = 7;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINES  = 1 << IDX_W;
    localparam int WORDS  = 1 << OFF_W;
    localparam int SLOT_W = IDX_W + OFF_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        tag_t tag;
        idx_t idx;
        off_t off;
    } waddr_t;

    typedef struct packed {
        logic   we;
        waddr_t a;
        word_t  wd;
    } cpu_op_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WMISS = 2'd1,
        ST_EVICT = 2'd2,
        ST_FILL  = 2'd3
    } ctl_st_t;

    localparam off_t LAST_OFF = off_t'(WORDS - 1);

    function automatic waddr_t split_addr(input logic [ADDR_W-1:0] a);
        return waddr_t'(a);
    endfunction

    function automatic slot_t slot_of(input idx_t i, input off_t o);
        return {i, o};
    endfunction
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store
    import dmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t rd_idx,
    output tag_t rd_tag,
    output logic rd_valid,
    output logic rd_dirty,
    input  logic fill_en,
    input  idx_t fill_idx,
    input  tag_t fill_tag,
    input  logic dirty_en,
    input  idx_t dirty_idx
);
    tag_t             tag_q [LINES];
    logic [LINES-1:0] vld_q;
    logic [LINES-1:0] drt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            drt_q <= '0;
        end else begin
            if (fill_en) begin
                vld_q[fill_idx] <= 1'b1;
                drt_q[fill_idx] <= 1'b0;
            end
            if (dirty_en) begin
                drt_q[dirty_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_tag;
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
    assign rd_dirty = drt_q[rd_idx];

    AST_INVALID_CLEAN: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> !rd_dirty); // R8
    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (vld_q[$past(fill_idx)] && !drt_q[$past(fill_idx)])); // R3
    AST_DIRTY_MARK: assert property (@(posedge clk) disable iff (rst)
        dirty_en |=> drt_q[$past(dirty_idx)]); // R5
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en,
    input  slot_t wr_slot,
    input  word_t wr_data,
    input  slot_t rd_slot,
    output word_t rd_data
);
    localparam int DEPTH = LINES * WORDS;

    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_slot] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_slot];
endmodule

// File: rtl/dmc_wb_cache.sv
module dmc_wb_cache
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_idle,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    ctl_st_t st_q;
    cpu_op_t op_q;
    off_t    cnt_q;
    logic    fwd_q;
    logic    done_q;
    word_t   rdata_q;

    waddr_t  la;
    tag_t    rd_tag;
    logic    rd_valid, rd_dirty;
    logic    hit, accept;
    slot_t   d_rslot, d_wslot;
    word_t   d_rdata, d_wdata;
    logic    d_we;
    logic    fill_en, dirty_en;

    assign la     = (st_q == ST_IDLE) ? split_addr(cpu_addr) : op_q.a;
    assign hit    = rd_valid && (rd_tag == la.tag);
    assign accept = (st_q == ST_IDLE) && cpu_req;

    dmc_tag_store u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (la.idx),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .fill_en  (fill_en),
        .fill_idx (op_q.a.idx),
        .fill_tag (op_q.a.tag),
        .dirty_en (dirty_en),
        .dirty_idx(la.idx)
    );

    dmc_data_store u_data (
        .clk    (clk),
        .wr_en  (d_we),
        .wr_slot(d_wslot),
        .wr_data(d_wdata),
        .rd_slot(d_rslot),
        .rd_data(d_rdata)
    );

    assign fill_en  = (st_q == ST_FILL) && mem_ack && (cnt_q == LAST_OFF);
    assign dirty_en = accept && cpu_we && hit;
    assign d_rslot  = (st_q == ST_EVICT) ? slot_of(op_q.a.idx, cnt_q) : slot_of(la.idx, la.off);

    always_comb begin
        d_we    = 1'b0;
        d_wslot = slot_of(la.idx, la.off);
        d_wdata = cpu_wdata;
        if (dirty_en) begin
            d_we = 1'b1;
        end else if ((st_q == ST_FILL) && mem_ack) begin
            d_we    = 1'b1;
            d_wslot = slot_of(op_q.a.idx, cnt_q);
            d_wdata = mem_rdata;
        end
    end

    always_comb begin
        mem_req   = (st_q != ST_IDLE);
        mem_we    = 1'b0;
        mem_addr  = op_q.a;
        mem_wdata = op_q.wd;
        case (st_q)
            ST_WMISS: mem_we = 1'b1;
            ST_EVICT: begin
                mem_we    = 1'b1;
                mem_addr  = {rd_tag, op_q.a.idx, cnt_q};
                mem_wdata = d_rdata;
            end
            ST_FILL:  mem_addr = {op_q.a.tag, op_q.a.idx, cnt_q};
            default:  mem_we = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            op_q    <= '0;
            cnt_q   <= '0;
            fwd_q   <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        op_q  <= '{we: cpu_we, a: la, wd: cpu_wdata};
                        cnt_q <= '0;
                        fwd_q <= 1'b0;
                        if (hit) begin
                            done_q <= 1'b1;
                            if (!cpu_we) rdata_q <= d_rdata;
                        end else if (cpu_we) begin
                            st_q <= ST_WMISS;
                        end else if (rd_valid && rd_dirty) begin
                            st_q <= ST_EVICT;
                        end else begin
                            st_q <= ST_FILL;
                        end
                    end
                end
                ST_WMISS: begin
                    if (mem_ack) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                ST_EVICT: begin
                    if (mem_ack) begin
                        cnt_q <= cnt_q + off_t'(1);
                        if (cnt_q == LAST_OFF) st_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        cnt_q <= cnt_q + off_t'(1);
                        if (cnt_q == op_q.a.off) begin
                            rdata_q <= mem_rdata;
                            done_q  <= 1'b1;
                            fwd_q   <= 1'b1;
                        end
                        if (cnt_q == LAST_OFF) st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_idle  = (st_q == ST_IDLE);
    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
    AST_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_FILL) && fwd_q) |=> !cpu_done); // R9
    AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_EVICT) && mem_ack && (cnt_q == LAST_OFF)) |=> ((st_q == ST_FILL) && (cnt_q == '0))); // R7
endmodule

// File: tb/dmc_wb_cache_tb.sv
`timescale 1ns/1ps
module dmc_wb_cache_tb_top;
    localparam logic [15:0] KEY = 16'hA5C3;
    localparam int NV = 14;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [15:0] wd;
        logic [15:0] exp;
        logic        hit;
        logic [4:0]  nw;
        logic [4:0]  nr;
        logic [15:0] vb;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h1234, 16'h0000, 16'h1234 ^ KEY, 1'b0, 5'd0,  5'd16, 16'h0000},
        '{1'b0, 16'h123F, 16'h0000, 16'h123F ^ KEY, 1'b1, 5'd0,  5'd0,  16'h0000},
        '{1'b1, 16'h1235, 16'hBEEF, 16'h0000,       1'b1, 5'd0,  5'd0,  16'h0000},
        '{1'b0, 16'h1235, 16'h0000, 16'hBEEF,       1'b1, 5'd0,  5'd0,  16'h0000},
        '{1'b1, 16'h9999, 16'h1111, 16'h0000,       1'b0, 5'd1,  5'd0,  16'h0000},
        '{1'b0, 16'h9999, 16'h0000, 16'h1111,       1'b0, 5'd0,  5'd16, 16'h0000},
        '{1'b0, 16'h1A34, 16'h0000, 16'h1A34 ^ KEY, 1'b0, 5'd16, 5'd16, 16'h1230},
        '{1'b0, 16'h1235, 16'h0000, 16'hBEEF,       1'b0, 5'd0,  5'd16, 16'h0000},
        '{1'b0, 16'h1A34, 16'h0000, 16'h1A34 ^ KEY, 1'b0, 5'd0,  5'd16, 16'h0000},
        '{1'b0, 16'h0000, 16'h0000, 16'h0000 ^ KEY, 1'b0, 5'd0,  5'd16, 16'h0000},
        '{1'b0, 16'h000F, 16'h0000, 16'h000F ^ KEY, 1'b1, 5'd0,  5'd0,  16'h0000},
        '{1'b0, 16'h2000, 16'h0000, 16'h2000 ^ KEY, 1'b0, 5'd0,  5'd16, 16'h0000},
        '{1'b0, 16'h300F, 16'h0000, 16'h300F ^ KEY, 1'b0, 5'd0,  5'd16, 16'h0000},
        '{1'b0, 16'h7FF0, 16'h0000, 16'h7FF0 ^ KEY, 1'b0, 5'd0,  5'd16, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_idle, cpu_done;
    logic [15:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dmc_wb_cache dut_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_idle(cpu_idle), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Main memory model: sparse contents, default word = address ^ KEY, variable latency
    logic [15:0] mem_m [int];
    int          lat_c = 0;
    int          ev_n = 0;
    logic        ev_we [1024];
    logic [15:0] ev_a  [1024];
    int          done_n = 0;
    bit          pend = 0;
    logic [15:0] pend_a = '0;
    logic        pend_we = 1'b0;
    int          hold_err = 0;

    function automatic logic [15:0] rd_mem(input logic [15:0] a);
        if (mem_m.exists(int'(a))) return mem_m[int'(a)];
        return a ^ KEY;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            lat_c   <= 0;
        end else if (mem_req && !mem_ack) begin
            if (lat_c >= int'(mem_addr[1:0])) begin
                mem_ack <= 1'b1;
                lat_c   <= 0;
                if (mem_we) mem_m[int'(mem_addr)] = mem_wdata;
                else mem_rdata <= rd_mem(mem_addr);
                ev_we[ev_n % 1024] = mem_we;
                ev_a[ev_n % 1024]  = mem_addr;
                ev_n++;
            end else begin
                lat_c <= lat_c + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (cpu_done) done_n++;
            if (pend && (!mem_req || mem_addr != pend_a || mem_we != pend_we)) hold_err++;
            pend    = mem_req && !mem_ack;
            pend_a  = mem_addr;
            pend_we = mem_we;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    int          r_lat, r_busy, r_base, r_dbase;
    logic [15:0] r_data;

    task automatic do_req(input logic we, input logic [15:0] a, input logic [15:0] wd, input bit rogue);
        @(negedge clk);
        while (!cpu_idle) @(negedge clk);
        r_base  = ev_n;
        r_dbase = done_n;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        r_lat = 1;
        while (!cpu_done) begin
            @(negedge clk);
            r_lat++;
        end
        r_data = cpu_rdata;
        r_busy = 0;
        if (rogue && !cpu_idle) begin
            cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = 16'hDEAD;
            @(negedge clk);
            cpu_req = 1'b0;
            r_busy++;
        end
        while (!cpu_idle) begin
            @(negedge clk);
            r_busy++;
        end
        @(negedge clk);
    endtask

    int nw_a, nr_a;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state: idle, no memory request, no completion
        chk(cpu_idle == 1'b1, "R2 idle after reset", 32'(cpu_idle), 1);
        chk(mem_req == 1'b0, "R2 no mem_req after reset", 32'(mem_req), 0);
        chk(cpu_done == 1'b0, "R2 no done after reset", 32'(cpu_done), 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            do_req(v.we, v.addr, v.wd, 1'b0);
            nw_a = 0; nr_a = 0;
            for (int k = r_base; k < ev_n; k++) begin
                if (ev_we[k % 1024]) nw_a++; else nr_a++;
            end
            if (!v.we) chk(r_data == v.exp, "R1 R4 read data", 32'(r_data), 32'(v.exp));
            if (v.hit) chk(r_lat == 1, "R1 R2 hit latency", r_lat, 1);
            else chk(r_lat > 1, "R2 R6 miss latency", r_lat, 2);
            chk(nw_a == int'(v.nw), "R5 R6 R7 R8 memory write count", nw_a, 32'(v.nw));
            chk(nr_a == int'(v.nr), "R3 R5 R6 refill read count", nr_a, 32'(v.nr));
            chk(done_n - r_dbase == 1, "R9 one done per request", done_n - r_dbase, 1);
            if (v.nw == 5'd16) begin
                for (int k = 0; k < 16; k++)
                    chk(ev_we[(r_base + k) % 1024] && ev_a[(r_base + k) % 1024] == v.vb + 16'(k),
                        "R7 write-back order", 32'(ev_a[(r_base + k) % 1024]), 32'(v.vb + 16'(k)));
            end
            if (v.nw == 5'd1)
                chk(ev_a[r_base % 1024] == v.addr, "R6 write-around address", 32'(ev_a[r_base % 1024]), 32'(v.addr));
            if (v.nr == 5'd16) begin
                for (int k = 0; k < 16; k++)
                    chk(!ev_we[(r_base + int'(v.nw) + k) % 1024] &&
                        ev_a[(r_base + int'(v.nw) + k) % 1024] == {v.addr[15:4], 4'(k)},
                        "R3 refill order", 32'(ev_a[(r_base + int'(v.nw) + k) % 1024]), 32'({v.addr[15:4], 4'(k)}));
                if (v.addr[3:0] != 4'hF) chk(r_busy > 0, "R4 early forward", r_busy, 1);
            end
        end

        // R9: a write request made while the refill is still running is ignored
        do_req(1'b0, 16'h4567, 16'h0000, 1'b1);
        chk(r_data == (16'h4567 ^ KEY), "R4 forwarded word", 32'(r_data), 32'(16'h4567 ^ KEY));
        chk(r_busy > 1, "R4 busy after forward", r_busy, 2);
        nw_a = 0;
        for (int k = r_base; k < ev_n; k++) if (ev_we[k % 1024]) nw_a++;
        chk(nw_a == 0, "R9 busy request made no memory write", nw_a, 0);
        do_req(1'b0, 16'h4567, 16'h0000, 1'b0);
        chk(r_data == (16'h4567 ^ KEY), "R9 busy request left line unchanged", 32'(r_data), 32'(16'h4567 ^ KEY));
        chk(r_lat == 1, "R1 line resident after refill", r_lat, 1);

        // R10: memory request held steady until acknowledge
        chk(hold_err == 0, "R10 request stability", hold_err, 0);
        finish_run();
    end
endmodule